// File: doc/BRIEF.md
# Firmware Write-Protection Control Register

This block is a 16-bit configuration register that decides whether bus write cycles may reach the address ranges of the boot firmware device. An external decoder reports, for each bus write, whether it targets a protected firmware range or the firmware device's own register space. The block then either forwards the write or flags it for a master-abort.

The register holds two control bits: a write-enable bit and a sticky lock bit. The lock bit can be set by software, but only the bus reset clears it. Once the lock is set, any register write that takes write-enable from 0 to 1 produces a one-cycle SMI request. A firmware handler can then decide whether to allow the write. The other bits are storage that software may read back, except for a group of bits that always read as zero.

Register writes go through a simple port with per-byte enables. Reads are combinational from the stored value.

Top module: `fw_wprot_ctl`

## Requirements
- R1: After a cycle with `rst_n` low, `reg_rdata` reads 16'h07C1 and `smi_req` is 0.
- R2: Bit 15 (lock) is set by a write with `reg_be[1]`=1 and `reg_wdata[15]`=1; a later write of 0 to bit 15 leaves it at 1.
- R3: Asserting `rst_n` low returns bit 15 to 0.
- R4: While bit 2 (write-enable) is 0, a request with `fw_range_hit`=1 and `fw_regspace_hit`=0 drives `fw_wr_abort`=1 and `fw_wr_fwd`=0 in the same cycle.
- R5: While bit 2 is 1, a request with `fw_range_hit`=1 drives `fw_wr_fwd`=1 and `fw_wr_abort`=0.
- R6: A request with `fw_regspace_hit`=1 is never aborted and is forwarded, whatever the value of bit 2.
- R7: A register write that changes bit 2 from 0 to 1 while the lock is 1 drives `smi_req` high for exactly the one cycle after the write edge.
- R8: A write that sets bit 2 while the lock is 0 and stays 0 produces no SMI request.
- R9: A write that leaves bit 2 at 1, when bit 2 was already 1, produces no SMI request.
- R10: A single write that sets bit 15 and raises bit 2 together produces an SMI request.
- R11: Bits 10:3 and 1:0 hold the written value, and bits 14:11 always read 0.
- R12: `reg_be[0]` gates bits 7:0 and `reg_be[1]` gates bits 15:8. A lane whose enable is 0 keeps its value, and a write with `reg_be[0]`=0 cannot raise bit 2 or request an SMI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low bus reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte enables, bit 0 for low byte |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Current register value |
| fw_wr_req | input | 1 | Bus write request present |
| fw_range_hit | input | 1 | Request targets a protected firmware range |
| fw_regspace_hit | input | 1 | Request targets firmware device register space |
| fw_wr_fwd | output | 1 | Forward the write |
| fw_wr_abort | output | 1 | Master-abort the write |
| smi_req | output | 1 | One-cycle SMI request |

## Verification
The gating path is driven with all three hit patterns: a range hit, a register-space hit, and both together. Each pattern is applied with write-enable low and with it high, which separates the range check from the register-space exemption. The SMI path is driven with four kinds of write. These are raising write-enable with no lock, raising it with the lock already set, setting lock and enable in one write, and rewriting an enable that is already 1. Together they separate edge detection from level detection and show that the new lock value applies to the same write. Lane-masked writes, including a high-lane-only write that carries a 1 in bit 2, show that each byte enable isolates its own lane.

// File: rtl/fw_wprot_pkg.sv
// Package: shared constants for the firmware write-protection register.
// Assumes a 16-bit register split into two byte lanes.
package fw_wprot_pkg;
    localparam int unsigned REG_W    = 16;
    localparam int unsigned LANE_W   = 8;
    localparam int unsigned LANES    = REG_W / LANE_W;
    localparam int unsigned LOCK_POS = 15;
    localparam int unsigned WEN_POS  = 2;
    localparam logic [REG_W-1:0] RST_VALUE = 16'h07C1;
    localparam logic [REG_W-1:0] RO_MASK   = 16'h7800;  // bits 14:11 fixed
    localparam logic [REG_W-1:0] STICKY    = 16'h8000;  // set-only bits
endpackage

// File: rtl/fw_wprot_reg.sv
// Module: register storage with byte-lane enables, fixed bits and a
// set-only lock bit. It also exposes the lock value that a write in
// progress would produce, so that the SMI logic can apply it to the same write.
// Assumes a synchronous active-low reset.
module fw_wprot_reg
    import fw_wprot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [LANES-1:0]  be,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  q,
    output logic              lock_next
);
    logic [REG_W-1:0] lane_mask;
    logic [REG_W-1:0] d;

    // Expand the byte enables to per-bit masks, one lane per generate step.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{wr & be[g]}};
    end

    // Next value: plain bits take the write data, sticky bits only set, fixed bits hold.
    always_comb begin
        d = (q & ~(lane_mask & ~RO_MASK & ~STICKY))
          | (wdata & lane_mask & ~RO_MASK & ~STICKY);
        d = d | (wdata & lane_mask & STICKY);
    end

    assign lock_next = d[LOCK_POS];

    // State update with synchronous reset to the documented value.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VALUE;
        else        q <= d;
    end
endmodule

// File: rtl/fw_wprot_smi.sv
// Module: turns a 0-to-1 write of the enable bit into a one-cycle SMI pulse,
// qualified by the lock value that applies to that write.
// Assumes the write strobe is one cycle per write.
module fw_wprot_smi (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_lo,
    input  logic wen_new,
    input  logic wen_cur,
    input  logic lock_next,
    output logic smi
);
    // Register the rising-edge condition so that the pulse lines up with the register update.
    always_ff @(posedge clk) begin
        if (!rst_n) smi <= 1'b0;
        else        smi <= wr_lo & wen_new & ~wen_cur & lock_next;
    end
endmodule

// File: rtl/fw_wprot_gate.sv
// Module: decides whether a bus write is forwarded or aborted.
// Assumes the hit inputs are valid in the same cycle as the request.
module fw_wprot_gate (
    input  logic req,
    input  logic range_hit,
    input  logic regspace_hit,
    input  logic wen,
    output logic fwd,
    output logic abort
);
    // Abort protected-range writes unless enabled; register space is exempt.
    always_comb begin
        abort = req & range_hit & ~regspace_hit & ~wen;
        fwd   = req & ~abort;
    end
endmodule

// File: rtl/fw_wprot_ctl.sv
// Module: top of the firmware write-protection control register.
// Connects storage, SMI pulse generation and the write gate.
// Assumes range decoding is done outside and supplied as hit flags.
module fw_wprot_ctl
    import fw_wprot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_be,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        fw_wr_req,
    input  logic        fw_range_hit,
    input  logic        fw_regspace_hit,
    output logic        fw_wr_fwd,
    output logic        fw_wr_abort,
    output logic        smi_req
);
    logic [REG_W-1:0] q;
    logic             lock_next;

    fw_wprot_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .be(reg_be),
        .wdata(reg_wdata), .q(q), .lock_next(lock_next)
    );

    fw_wprot_smi u_smi (
        .clk(clk), .rst_n(rst_n), .wr_lo(reg_wr & reg_be[WEN_POS / LANE_W]),
        .wen_new(reg_wdata[WEN_POS]), .wen_cur(q[WEN_POS]),
        .lock_next(lock_next), .smi(smi_req)
    );

    fw_wprot_gate u_gate (
        .req(fw_wr_req), .range_hit(fw_range_hit), .regspace_hit(fw_regspace_hit),
        .wen(q[WEN_POS]), .fwd(fw_wr_fwd), .abort(fw_wr_abort)
    );

    assign reg_rdata = q;
endmodule

// File: rtl/fw_wprot_ctl_chk.sv
// Checker: temporal properties of the write-protection register, bound to the top.
module fw_wprot_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] reg_rdata,
    input logic        fw_regspace_hit,
    input logic        fw_wr_fwd,
    input logic        fw_wr_abort,
    input logic        smi_req
);
    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[15] |=> reg_rdata[15]);
    p_abort_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fw_wr_abort |-> (!fw_wr_fwd && !reg_rdata[2]));
    p_fwd_when_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[2] |-> !fw_wr_abort);
    p_regspace_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fw_regspace_hit |-> !fw_wr_abort);
    p_smi_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |=> !smi_req);
    p_smi_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> (reg_rdata[2] && reg_rdata[15] && !$past(reg_rdata[2])));
    p_fixed_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[14:11] == 4'b0000);
endmodule

bind fw_wprot_ctl fw_wprot_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata),
    .fw_regspace_hit(fw_regspace_hit), .fw_wr_fwd(fw_wr_fwd),
    .fw_wr_abort(fw_wr_abort), .smi_req(smi_req)
);

// File: tb/tb_fw_wprot_ctl.sv
module tb_fw_wprot_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        fw_wr_req = 1'b0;
    logic        fw_range_hit = 1'b0;
    logic        fw_regspace_hit = 1'b0;
    logic        fw_wr_fwd;
    logic        fw_wr_abort;
    logic        smi_req;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fw_wprot_ctl dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // Returns at the negedge after the write edge, when smi_req is valid.
    task automatic do_write(input logic [1:0] be, input logic [15:0] data);
        @(negedge clk); reg_wr = 1'b1; reg_be = be; reg_wdata = data;
        @(negedge clk); reg_wr = 1'b0; reg_be = 2'b00; reg_wdata = 16'h0;
    endtask

    task automatic probe(input bit rng, input bit rsp, input bit efwd, input bit eab, input string req);
        fw_wr_req = 1'b1; fw_range_hit = rng; fw_regspace_hit = rsp;
        #1;
        check(fw_wr_fwd == efwd && fw_wr_abort == eab, req, {fw_wr_fwd, fw_wr_abort}, {efwd, eab});
        fw_wr_req = 1'b0; fw_range_hit = 1'b0; fw_regspace_hit = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(reg_rdata == 16'h07C1, "R1", reg_rdata, 16'h07C1);
        check(smi_req == 1'b0, "R1", smi_req, 0);
    endtask

    task automatic t_storage();
        do_write(2'b11, 16'h7AF9);
        check(reg_rdata == 16'h02F9, "R11", reg_rdata, 16'h02F9);
        do_write(2'b01, 16'hFF04);
        check(smi_req == 1'b0, "R8", smi_req, 0);
        check(reg_rdata == 16'h0204, "R12", reg_rdata, 16'h0204);
        do_write(2'b10, 16'h05FF);
        check(reg_rdata == 16'h0504, "R12", reg_rdata, 16'h0504);
    endtask

    task automatic t_gate();
        probe(1'b1, 1'b0, 1'b1, 1'b0, "R5");
        probe(1'b1, 1'b1, 1'b1, 1'b0, "R6");
        do_write(2'b01, 16'h0000);
        probe(1'b1, 1'b0, 1'b0, 1'b1, "R4");
        probe(1'b0, 1'b1, 1'b1, 1'b0, "R6");
        probe(1'b1, 1'b1, 1'b1, 1'b0, "R6");
    endtask

    task automatic t_lock();
        do_write(2'b10, 16'h8000);
        check(reg_rdata == 16'h8000, "R2", reg_rdata, 16'h8000);
        do_write(2'b10, 16'h0000);
        check(reg_rdata[15] == 1'b1, "R2", reg_rdata[15], 1);
        do_write(2'b10, 16'h0004);
        check(smi_req == 1'b0 && reg_rdata[2] == 1'b0, "R12", {smi_req, reg_rdata[2]}, 0);
        do_write(2'b01, 16'h0004);
        check(smi_req == 1'b1, "R7", smi_req, 1);
        @(negedge clk);
        check(smi_req == 1'b0, "R7", smi_req, 0);
        do_write(2'b01, 16'h0004);
        check(smi_req == 1'b0, "R9", smi_req, 0);
        do_reset();
        check(reg_rdata[15] == 1'b0, "R3", reg_rdata[15], 0);
    endtask

    task automatic t_same_write();
        do_write(2'b11, 16'h8004);
        check(smi_req == 1'b1, "R10", smi_req, 1);
        check(reg_rdata == 16'h8004, "R10", reg_rdata, 16'h8004);
    endtask

    initial begin
        t_reset();
        t_storage();
        t_gate();
        t_lock();
        t_same_write();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule